// File: doc/BRIEF.md
# Decimal Event Timer with Alarm Compare

This block is the event timer of a real-time clock. It keeps a two-digit BCD count from 00 to 99. The count advances on pulses from one of several timebase sources, and that source is chosen by a 3-bit resolution field. Software can load the count at any time. After 99 the count returns to 00 and raises a sticky wrap flag. A second sticky flag is raised when the count arrives at a programmable BCD alarm value. Only software clears either flag.

Software reaches four byte registers through a single-cycle byte port. A write takes effect on the clock edge and reads are combinational. The registers are control/status at 0h, count at 7h, alarm control at 8h and alarm value at Fh. An active-low interrupt output is asserted while either flag is set and its own routing enable is on.

Top module: `rtc_event_timer`

## Requirements
- R1: After reset, all four registers read 00h and `irq_n` is high.
- R2: A write to address 0h, 7h, 8h or Fh stores the byte, and a later read of that address returns it. Any other address reads 00h, and a write to it has no effect on the four registers.
- R3: The count advances only while control bit 2 is 1 and control bit 5 is 0. With any other setting of those two bits, tick pulses leave the count unchanged.
- R4: Alarm-control bits [2:0] select the tick source from `tick_src`. The codes are 001 = bit 0 (1/100 s), 010 = bit 1 (seconds), 011 = bit 2 (minutes), 100 = bit 3 (hours) and 101 = bit 4 (days). Codes 000, 110 and 111 select no source.
- R5: Each selected tick adds one to the BCD count. A units digit of 9 becomes 0 and carries into the tens digit, so 09h becomes 10h and 99h becomes 00h.
- R6: Each wrap from 99h to 00h sets control bit 0. The bit stays set through later ticks and is cleared only by a software write of 0 to that bit.
- R7: While alarm-control bit 6 is 1, control bit 1 is set on the clock edge after the count becomes equal to the alarm value. It is not set again while the equality simply persists. When bit 6 is 0, a match sets nothing.
- R8: `irq_n` is low exactly when (control bit 0 AND alarm-control bit 3) OR (control bit 1 AND alarm-control bit 7).
- R9: When a software write to the count and a selected tick occur in the same cycle, the written value is stored.
- R10: When a software write clears a flag in the same cycle that hardware sets it, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| we | input | 1 | Write strobe for the register port |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| tick_src | input | 5 | One-cycle timebase pulses: 1/100 s, s, min, h, day |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest case to reach is the alarm edge. After software clears the alarm flag while the count still equals the alarm value, the flag must stay clear. The stimulus first steps the count onto the alarm value and confirms the flag. It then clears the flag without moving the count and checks that the flag stays clear. Finally it loads a different value and ticks back onto the alarm value to show that a new arrival sets the flag again. The two same-cycle collisions, a count write against a tick and a flag clear against a wrap, are produced by driving the write strobe and a tick pulse on the same clock edge.

// File: rtl/rtc_event_timer.sv
module rtc_event_timer #(
  parameter int unsigned NSRC = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [3:0]      addr,
  input  logic [7:0]      wdata,
  output logic [7:0]      rdata,
  input  logic [NSRC-1:0] tick_src,
  output logic            irq_n
);
  localparam logic [3:0] A_CTRL = 4'h0;
  localparam logic [3:0] A_CNT  = 4'h7;
  localparam logic [3:0] A_ACTL = 4'h8;
  localparam logic [3:0] A_ALM  = 4'h9 + 4'h6;

  logic [7:0] ctrl, actl, cnt, alm;
  logic       sel_tick, adv, wrap, ovf_set, alm_set, hit, hit_q;
  logic [7:0] cnt_inc;

  wire wr_ctrl = we && addr == A_CTRL;
  wire wr_cnt  = we && addr == A_CNT;
  wire wr_actl = we && addr == A_ACTL;
  wire wr_alm  = we && addr == A_ALM;
  wire run     = ctrl[2] && !ctrl[5];

  always_comb begin
    sel_tick = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (32'(actl[2:0]) == i + 1) sel_tick = tick_src[i];
  end

  assign adv = run && sel_tick;

  wire lo_top = cnt[3:0] >= 4'd9;
  wire hi_top = cnt[7:4] >= 4'd9;
  assign wrap    = lo_top && hi_top;
  assign cnt_inc = !lo_top ? {cnt[7:4], cnt[3:0] + 4'd1}
                 : hi_top  ? 8'h00
                 :           {cnt[7:4] + 4'd1, 4'h0};

  assign ovf_set = adv && wrap && !wr_cnt;
  assign hit     = actl[6] && cnt == alm;
  assign alm_set = hit && !hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      actl  <= '0;
      cnt   <= '0;
      alm   <= '0;
      hit_q <= 1'b0;
    end else begin
      hit_q <= hit;
      if (wr_cnt)    cnt <= wdata;
      else if (adv)  cnt <= cnt_inc;
      if (wr_actl)   actl <= wdata;
      if (wr_alm)    alm  <= wdata;
      if (wr_ctrl)   ctrl <= {wdata[7:2], wdata[1] | alm_set, wdata[0] | ovf_set};
      else           ctrl <= {ctrl[7:2], ctrl[1] | alm_set, ctrl[0] | ovf_set};
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rdata = ctrl;
      A_CNT:   rdata = cnt;
      A_ACTL:  rdata = actl;
      A_ALM:   rdata = alm;
      default: rdata = 8'h00;
    endcase
  end

  assign irq_n = !((ctrl[0] && actl[3]) || (ctrl[1] && actl[7]));
endmodule

module rtc_event_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       we,
  input logic [3:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] ctrl,
  input logic [7:0] actl,
  input logic [7:0] cnt,
  input logic       adv,
  input logic       irq_n
);
  // R6
  timer_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] && !(we && addr == 4'h0 && !wdata[0])) |=> ctrl[0]);
  // R3
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ctrl[2] && !ctrl[5]) && !(we && addr == 4'h7)) |=> $stable(cnt));
  // R5
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cnt == 8'h99 && !(we && addr == 4'h7)) |=> cnt == 8'h00);
  // R9
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 4'h7) |=> cnt == $past(wdata));
  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!actl[3] && !actl[7]) |-> irq_n);
endmodule

bind rtc_event_timer rtc_event_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
  .ctrl(ctrl), .actl(actl), .cnt(cnt), .adv(adv), .irq_n(irq_n)
);

// File: tb/rtc_event_timer_tb.sv
`timescale 1ns/1ps
module rtc_event_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [4:0] tick_src = '0;
  logic       irq_n;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  rtc_event_timer u_dut (
    .clk(clk), .rst_n(rst_n), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tick_src(tick_src), .irq_n(irq_n)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic tick(input int b);
    @(negedge clk); tick_src[b] = 1'b1;
    @(negedge clk); tick_src = '0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(4'h0, v); chk("R1 ctrl", v, 8'h00);
    rd(4'h7, v); chk("R1 count", v, 8'h00);
    rd(4'h8, v); chk("R1 alarm ctrl", v, 8'h00);
    rd(4'hF, v); chk("R1 alarm", v, 8'h00);
    chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    wr(4'hF, 8'h42); rd(4'hF, v); chk("R2 alarm rw", v, 8'h42);
    wr(4'h8, 8'h02); rd(4'h8, v); chk("R2 alarm ctrl rw", v, 8'h02);
    wr(4'h7, 8'h37); rd(4'h7, v); chk("R2 count rw", v, 8'h37);
    wr(4'h3, 8'hAA); rd(4'h3, v); chk("R2 unmapped", v, 8'h00);
    rd(4'hF, v); chk("R2 unmapped write no effect", v, 8'h42);
    wr(4'h0, 8'hD0); rd(4'h0, v); chk("R2 ctrl rw", v, 8'hD0);
    wr(4'h0, 8'h00);
  endtask

  task automatic t_bcd;
    logic [7:0] v;
    wr(4'h8, 8'h01); wr(4'h7, 8'h08); wr(4'h0, 8'h04);
    tick(0); rd(4'h7, v); chk("R5 08->09", v, 8'h09);
    tick(0); rd(4'h7, v); chk("R5 09->10", v, 8'h10);
    wr(4'h7, 8'h98);
    tick(0); rd(4'h7, v); chk("R5 98->99", v, 8'h99);
    rd(4'h0, v); chk("R6 no flag before wrap", v, 8'h04);
    tick(0); rd(4'h7, v); chk("R5 99->00", v, 8'h00);
    rd(4'h0, v); chk("R6 flag on wrap", v, 8'h05);
    tick(0); rd(4'h0, v); chk("R6 flag sticky", v, 8'h05);
    wr(4'h0, 8'h04); rd(4'h0, v); chk("R6 software clear", v, 8'h04);
  endtask

  task automatic t_enable;
    logic [7:0] v;
    wr(4'h7, 8'h20); wr(4'h0, 8'h24);
    tick(0); rd(4'h7, v); chk("R3 bit5 set holds", v, 8'h20);
    wr(4'h0, 8'h00);
    tick(0); rd(4'h7, v); chk("R3 bit2 clear holds", v, 8'h20);
    wr(4'h0, 8'h04);
    tick(0); rd(4'h7, v); chk("R3 running", v, 8'h21);
  endtask

  task automatic t_res;
    logic [7:0] v;
    for (int r = 0; r < 8; r++) begin
      wr(4'h8, 8'(r));
      for (int j = 0; j < 5; j++) begin
        wr(4'h7, 8'h00);
        tick(j);
        rd(4'h7, v);
        chk($sformatf("R4 res %0d src %0d", r, j), v,
            (r >= 1 && r <= 5 && j == r - 1) ? 8'h01 : 8'h00);
      end
    end
  endtask

  task automatic t_alarm;
    logic [7:0] v;
    wr(4'h7, 8'h03); wr(4'hF, 8'h05); wr(4'h8, 8'h41); wr(4'h0, 8'h04);
    tick(0); @(negedge clk); rd(4'h0, v); chk("R7 no match", v, 8'h04);
    tick(0); @(negedge clk); rd(4'h0, v); chk("R7 match sets", v, 8'h06);
    chk("R8 alarm irq not routed", {7'd0, irq_n}, 8'h01);
    wr(4'h8, 8'hC1);
    chk("R8 alarm irq routed", {7'd0, irq_n}, 8'h00);
    wr(4'h0, 8'h04); @(negedge clk); @(negedge clk);
    rd(4'h0, v); chk("R7 persisting match no reset", v, 8'h04);
    chk("R8 irq released", {7'd0, irq_n}, 8'h01);
    wr(4'h7, 8'h04); tick(0); @(negedge clk);
    rd(4'h0, v); chk("R7 new arrival sets", v, 8'h06);
    chk("R8 irq low again", {7'd0, irq_n}, 8'h00);
    wr(4'h0, 8'h04); wr(4'h8, 8'h01); wr(4'h7, 8'h04);
    tick(0); @(negedge clk); rd(4'h0, v); chk("R7 disabled no set", v, 8'h04);
    wr(4'h8, 8'h09); wr(4'h7, 8'h99);
    chk("R8 timer irq idle", {7'd0, irq_n}, 8'h01);
    tick(0); chk("R8 timer irq on wrap", {7'd0, irq_n}, 8'h00);
    wr(4'h0, 8'h04);
    chk("R8 timer irq cleared", {7'd0, irq_n}, 8'h01);
  endtask

  task automatic t_collide;
    logic [7:0] v;
    wr(4'h8, 8'h01); wr(4'h0, 8'h04); wr(4'h7, 8'h10);
    @(negedge clk); we = 1'b1; addr = 4'h7; wdata = 8'h50; tick_src[0] = 1'b1;
    @(negedge clk); we = 1'b0; tick_src = '0;
    rd(4'h7, v); chk("R9 write beats tick", v, 8'h50);
    wr(4'h7, 8'h99);
    @(negedge clk); we = 1'b1; addr = 4'h0; wdata = 8'h04; tick_src[0] = 1'b1;
    @(negedge clk); we = 1'b0; tick_src = '0;
    rd(4'h0, v); chk("R10 set beats clear", v, 8'h05);
    rd(4'h7, v); chk("R10 count wrapped", v, 8'h00);
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #12 rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_regs;
    t_bcd;
    t_enable;
    t_res;
    t_alarm;
    t_collide;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule